// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the control state machine in front of a successive-approximation converter core. It decides when a conversion request goes to the core. Its inputs are a comparator power-enable bit, a conversion-start bit, a trigger-mode select, a conversion-style select and an external hardware trigger. The core is abstract. It sees a level request, `conv_req_o`, and after its own fixed conversion time it answers with a one-cycle `core_done_i`. The register bits appear as plain ports: write strobes come in and the current bit values go out.

There are three trigger modes:
- **Software:** the start bit launches work directly.
- **Hardware no-wait:** the start bit arms the block, and each trigger edge launches work.
- **Hardware wait:** software cannot set the start bit. A trigger sets it and is always followed by a power-stabilization interval.

In software and no-wait modes, the stabilization interval is inserted once after the comparator is powered. Its length comes from the channel class. Three conversion styles are supported:
- **One-shot:** one conversion per launch.
- **Sequential:** back-to-back conversions until the start bit is cleared.
- **Scan:** slots 0 to 3 in turn, then back to trigger standby.

A one-cycle completion strobe is raised after every conversion, and it carries the index of the slot that finished.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `comp_en_o`, `start_o`, `conv_req_o`, `conv_cmpl_o` are 0 and `slot_o` is 0.
- R2: A write to the power-enable bit (`en_wr_i`, data `en_wdata_i`) takes effect at the next edge only when `start_o` is 0; while `start_o` is 1 the write is ignored.
- R3: In software mode (`mode_sel_i` = 2'b00), `start_set_i` sets `start_o` only when `comp_en_o` is 1. A set start bit launches a conversion. A one-shot (`style_sel_i` = 2'b00) clears `start_o` after its completion strobe.
- R4: In software and no-wait modes, the first launch after the comparator is enabled passes through a stabilization interval. It lasts STAB_SLOW_CYC cycles when `chan_fast_i` = 0 and STAB_FAST_CYC cycles when it is 1. Later launches skip it. The request rises STAB+2 edges after a software start pulse (2 when skipped). After a trigger edge it rises STAB+3 edges later (3 when skipped).
- R5: In hardware wait mode (`mode_sel_i` = 2'b1x), `start_set_i` is ignored. A detected trigger sets `start_o` and always runs the stabilization interval first, so the request rises STAB+3 edges after the trigger. A one-shot then clears `start_o`.
- R6: In hardware no-wait mode (`mode_sel_i` = 2'b01), a software-set start bit arms the block without converting. Each trigger edge launches a conversion. `start_o` stays 1 after a one-shot completes.
- R7: A trigger edge that arrives while a conversion is in progress is ignored and launches no further conversion.
- R8: In sequential style (`style_sel_i` = 2'b01), a new request follows each completion on the next cycle, with no stabilization interval, until the start bit is cleared.
- R9: In scan style (`style_sel_i` = 2'b1x), slots 0, 1, 2, 3 convert back to back, and `slot_o` equals the finished slot during each strobe. After slot 3 the index returns to 0 and the block waits for the next launch. `start_o` is cleared in software and wait modes and kept in no-wait mode.
- R10: `start_clr_i` clears `start_o` and drops `conv_req_o` at the next edge from any state, and the abandoned conversion produces no strobe.
- R11: `conv_cmpl_o` is high for exactly one cycle per `core_done_i` and `conv_req_o` stays high until `core_done_i` or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr_i | input | 1 | Write strobe for the comparator power-enable bit |
| en_wdata_i | input | 1 | Value written to the power-enable bit |
| start_set_i | input | 1 | Software write of 1 to the start bit |
| start_clr_i | input | 1 | Software write of 0 to the start bit |
| mode_sel_i | input | 2 | 00 software, 01 hardware no-wait, 1x hardware wait |
| style_sel_i | input | 2 | 00 one-shot, 01 sequential, 1x scan |
| chan_fast_i | input | 1 | 1 selects the short stabilization class |
| hw_trig_i | input | 1 | Asynchronous hardware trigger, rising edge active |
| core_done_i | input | 1 | One-cycle done pulse from the converter core |
| comp_en_o | output | 1 | Current power-enable bit |
| start_o | output | 1 | Current start bit |
| conv_req_o | output | 1 | Conversion request to the core |
| conv_cmpl_o | output | 1 | One-cycle completion strobe |
| slot_o | output | 2 | Scan slot being converted |

## Verification
A wrong state shows up at the ports as a conversion request that rises on the wrong edge. The bench counts edges from each stimulus to that rise, so a stabilization interval that is missing, repeated or of the wrong class is seen within a few tens of cycles. A state that fails to leave a conversion, or leaves it twice, shows either as a strobe the scoreboard did not expect or as a slot index that does not match the queued one, at that very strobe. A wrong end-of-group decision shows as a start bit that is wrong in the cycle after the last strobe, and as a request that reappears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_STOPPED,
    ST_STANDBY,
    ST_TRIG_WAIT,
    ST_STABILIZE,
    ST_CONVERT,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    TM_SW,
    TM_NOWAIT,
    TM_WAIT
  } trig_mode_e;

  typedef enum logic [1:0] {
    CS_ONESHOT,
    CS_SEQ,
    CS_SCAN
  } conv_style_e;

  function automatic trig_mode_e decode_mode(input logic [1:0] sel);
    if (sel[1])               return TM_WAIT;
    else if (sel[0])          return TM_NOWAIT;
    else                      return TM_SW;
  endfunction

  function automatic conv_style_e decode_style(input logic [1:0] sel);
    if (sel[1])               return CS_SCAN;
    else if (sel[0])          return CS_SEQ;
    else                      return CS_ONESHOT;
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);

  logic [SYNC_STAGES:0] shift_q;
  logic [SYNC_STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], trig_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise_o = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

endmodule

// File: rtl/adc_stab_timer.sv
module adc_stab_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_en_i,
  input  logic              start_q_i,
  input  logic              start_clr_i,
  input  trig_mode_e        mode_i,
  input  conv_style_e       style_i,
  input  logic              trig_rise_i,
  input  logic              core_done_i,
  input  logic              stab_zero_i,
  output logic              stab_load_o,
  output logic              stab_run_o,
  output logic              trig_take_o,
  output logic              grp_end_o,
  output logic              conv_req_o,
  output logic              conv_cmpl_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              warm_q, warm_d;
  logic              last_slot;

  assign last_slot = (slot_q == SLOT_LAST);

  always_comb begin
    grp_end_o   = (state_q == ST_DONE) &&
                  ((style_i == CS_ONESHOT) || ((style_i == CS_SCAN) && last_slot));
    trig_take_o = comp_en_i && !start_clr_i && (state_q == ST_STANDBY) &&
                  (mode_i == TM_WAIT) && trig_rise_i;
  end

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    warm_d  = comp_en_i ? warm_q : 1'b0;
    if (!comp_en_i) begin
      state_d = ST_STOPPED;
      slot_d  = '0;
    end else if (start_clr_i) begin
      state_d = ST_STANDBY;
      slot_d  = '0;
    end else begin
      case (state_q)
        ST_STOPPED: state_d = ST_STANDBY;
        ST_STANDBY: begin
          if (mode_i == TM_WAIT) begin
            if (trig_rise_i) state_d = ST_STABILIZE;
          end else if (start_q_i) begin
            if (mode_i == TM_SW) state_d = warm_q ? ST_CONVERT : ST_STABILIZE;
            else                 state_d = ST_TRIG_WAIT;
          end
        end
        ST_TRIG_WAIT: begin
          if (trig_rise_i) state_d = warm_q ? ST_CONVERT : ST_STABILIZE;
        end
        ST_STABILIZE: begin
          if (stab_zero_i) begin
            state_d = ST_CONVERT;
            warm_d  = 1'b1;
          end
        end
        ST_CONVERT: begin
          if (core_done_i) state_d = ST_DONE;
        end
        ST_DONE: begin
          if (style_i == CS_SCAN) slot_d = last_slot ? '0 : slot_q + 1'b1;
          if (!grp_end_o)              state_d = ST_CONVERT;
          else if (mode_i == TM_NOWAIT) state_d = ST_TRIG_WAIT;
          else                         state_d = ST_STANDBY;
        end
        default: state_d = ST_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STOPPED;
      slot_q  <= '0;
      warm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      warm_q  <= warm_d;
    end
  end

  assign stab_load_o = (state_d == ST_STABILIZE) && (state_q != ST_STABILIZE);
  assign stab_run_o  = (state_q == ST_STABILIZE);
  assign conv_req_o  = (state_q == ST_CONVERT);
  assign conv_cmpl_o = (state_q == ST_DONE);
  assign slot_o      = slot_q;

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int STAB_FAST_CYC = 4,
  parameter int STAB_SLOW_CYC = 16,
  parameter int NUM_SLOTS     = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr_i,
  input  logic       en_wdata_i,
  input  logic       start_set_i,
  input  logic       start_clr_i,
  input  logic [1:0] mode_sel_i,
  input  logic [1:0] style_sel_i,
  input  logic       chan_fast_i,
  input  logic       hw_trig_i,
  input  logic       core_done_i,
  output logic       comp_en_o,
  output logic       start_o,
  output logic       conv_req_o,
  output logic       conv_cmpl_o,
  output logic [1:0] slot_o
);

  localparam int STAB_MAX = (STAB_SLOW_CYC > STAB_FAST_CYC) ? STAB_SLOW_CYC : STAB_FAST_CYC;
  localparam int CNT_W    = $clog2(STAB_MAX + 1);
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  trig_mode_e  mode;
  conv_style_e style;
  logic        comp_en_q, comp_en_d, comp_en_we;
  logic        start_q, start_d;
  logic        trig_rise, trig_take, grp_end;
  logic        stab_load, stab_run, stab_zero;
  logic [CNT_W-1:0]  stab_len;
  logic [SLOT_W-1:0] slot;

  assign mode  = decode_mode(mode_sel_i);
  assign style = decode_style(style_sel_i);

  always_comb begin
    comp_en_we = en_wr_i && !start_q;
    comp_en_d  = en_wdata_i;
  end

  always_comb begin
    start_d = start_q;
    if (start_clr_i)                                       start_d = 1'b0;
    else if (trig_take)                                    start_d = 1'b1;
    else if (start_set_i && comp_en_q && mode != TM_WAIT)  start_d = 1'b1;
    else if (grp_end && mode != TM_NOWAIT)                 start_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_en_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      if (comp_en_we) comp_en_q <= comp_en_d;
      start_q <= start_d;
    end
  end

  assign stab_len = chan_fast_i ? CNT_W'(STAB_FAST_CYC - 1) : CNT_W'(STAB_SLOW_CYC - 1);

  adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (hw_trig_i),
    .rise_o (trig_rise)
  );

  adc_stab_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (stab_load),
    .load_val_i (stab_len),
    .run_i      (stab_run),
    .zero_o     (stab_zero)
  );

  adc_seq_fsm #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .comp_en_i   (comp_en_q),
    .start_q_i   (start_q),
    .start_clr_i (start_clr_i),
    .mode_i      (mode),
    .style_i     (style),
    .trig_rise_i (trig_rise),
    .core_done_i (core_done_i),
    .stab_zero_i (stab_zero),
    .stab_load_o (stab_load),
    .stab_run_o  (stab_run),
    .trig_take_o (trig_take),
    .grp_end_o   (grp_end),
    .conv_req_o  (conv_req_o),
    .conv_cmpl_o (conv_cmpl_o),
    .slot_o      (slot)
  );

  assign comp_en_o = comp_en_q;
  assign start_o   = start_q;
  assign slot_o    = 2'(slot);

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr_i,
  input logic       start_clr_i,
  input logic [1:0] mode_sel_i,
  input logic       core_done_i,
  input logic       comp_en_o,
  input logic       start_o,
  input logic       conv_req_o,
  input logic       conv_cmpl_o,
  input logic       trig_take
);

  AST_CMPL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cmpl_o |=> !conv_cmpl_o); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o && !core_done_i && !start_clr_i |=> conv_req_o); // R11

  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i && start_o |=> $stable(comp_en_o)); // R2

  AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr_i |=> !conv_req_o && !start_o); // R10

  AST_WAIT_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel_i[1] && !start_o && !trig_take |=> !start_o); // R5

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> start_o && comp_en_o); // R3

endmodule

bind adc_trig_seq adc_trig_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_wr_i     (en_wr_i),
  .start_clr_i (start_clr_i),
  .mode_sel_i  (mode_sel_i),
  .core_done_i (core_done_i),
  .comp_en_o   (comp_en_o),
  .start_o     (start_o),
  .conv_req_o  (conv_req_o),
  .conv_cmpl_o (conv_cmpl_o),
  .trig_take   (trig_take)
);

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_FAST     = 4;
  localparam int N_SLOW     = 16;
  localparam int CONV_CYC   = 8;

  logic       clk;
  logic       rst_n;
  logic       en_wr, en_wdata, start_set, start_clr, chan_fast, hw_trig, core_done;
  logic [1:0] mode_sel, style_sel;
  logic       comp_en, start_bit, conv_req, conv_cmpl;
  logic [1:0] slot;

  int total;
  int bad;
  int exp_q[$];
  int core_cnt;
  bit ended;

  adc_trig_seq #(.STAB_FAST_CYC(N_FAST), .STAB_SLOW_CYC(N_SLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .start_set_i(start_set), .start_clr_i(start_clr), .mode_sel_i(mode_sel),
    .style_sel_i(style_sel), .chan_fast_i(chan_fast), .hw_trig_i(hw_trig),
    .core_done_i(core_done), .comp_en_o(comp_en), .start_o(start_bit),
    .conv_req_o(conv_req), .conv_cmpl_o(conv_cmpl), .slot_o(slot)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // converter core model: done pulse CONV_CYC cycles after request rises
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_cnt  <= 0;
      core_done <= 1'b0;
    end else if (!conv_req || core_done) begin
      core_cnt  <= 0;
      core_done <= 1'b0;
    end else begin
      core_cnt  <= core_cnt + 1;
      core_done <= (core_cnt == CONV_CYC - 1);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the next queued slot
  always @(negedge clk) begin
    if (rst_n && conv_cmpl) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11: actual=unexpected strobe expected=none (slot %0d)", slot);
      end else begin
        chk("R9 slot at strobe", int'(slot), exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  task automatic pulse_start_measure(output int cnt);
    start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    cnt = 1;
    while (!conv_req && cnt < 500) begin @(negedge clk); cnt++; end
  endtask

  task automatic pulse_trig_measure(output int cnt);
    hw_trig = 1'b1;
    @(negedge clk); hw_trig = 1'b0;
    cnt = 1;
    while (!conv_req && cnt < 500) begin @(negedge clk); cnt++; end
  endtask

  task automatic wait_cmpl(input string req);
    int g = 0;
    while (!conv_cmpl && g < 500) begin @(negedge clk); g++; end
    if (g >= 500) chk(req, 0, 1);
  endtask

  task automatic write_en(input logic v);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    start_clr = 1'b1;
    @(negedge clk); start_clr = 1'b0;
  endtask

  initial begin
    int cnt;
    total = 0; bad = 0; ended = 1'b0;
    rst_n = 1'b0; en_wr = 0; en_wdata = 0; start_set = 0; start_clr = 0;
    chan_fast = 0; hw_trig = 0; mode_sel = 2'b00; style_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 comp_en", comp_en, 0);
    chk("R1 start", start_bit, 0);
    chk("R1 conv_req", conv_req, 0);
    chk("R1 cmpl", conv_cmpl, 0);
    chk("R1 slot", slot, 0);

    // R3: start ignored while comparator off
    start_set = 1'b1; @(negedge clk); start_set = 1'b0; @(negedge clk);
    chk("R3 start needs enable", start_bit, 0);

    write_en(1'b1);
    chk("R2 enable write", comp_en, 1);

    // software one-shot, cold then warm (R3, R4)
    exp_q.push_back(0);
    pulse_start_measure(cnt);
    chk("R4 cold sw slow latency", cnt, N_SLOW + 2);
    wait_cmpl("R3 completion");
    @(negedge clk);
    chk("R11 strobe one cycle", conv_cmpl, 0);
    chk("R3 one-shot clears start", start_bit, 0);
    exp_q.push_back(0);
    pulse_start_measure(cnt);
    chk("R4 warm sw latency", cnt, 2);
    wait_cmpl("R3 completion");
    @(negedge clk);

    // software sequential with locked enable write (R2, R8, R10)
    style_sel = 2'b01;
    repeat (3) exp_q.push_back(0);
    pulse_start_measure(cnt);
    write_en(1'b0);
    chk("R2 enable locked while started", comp_en, 1);
    for (int i = 0; i < 3; i++) begin
      wait_cmpl("R8 completion");
      if (i < 2) begin
        @(negedge clk);
        chk("R8 back-to-back request", conv_req, 1);
      end
    end
    pulse_clr();
    chk("R10 clear drops request", conv_req, 0);
    chk("R10 clear drops start", start_bit, 0);

    // abort mid-conversion (R10)
    pulse_start_measure(cnt);
    repeat (2) @(negedge clk);
    pulse_clr();
    chk("R10 abort drops request", conv_req, 0);
    repeat (12) @(negedge clk);
    chk("R10 no strobe after abort", conv_req, 0);

    write_en(1'b0);
    chk("R2 disable write", comp_en, 0);
    chan_fast = 1'b1;
    write_en(1'b1);

    // hardware no-wait one-shot (R4, R6, R7)
    mode_sel = 2'b01; style_sel = 2'b00;
    start_set = 1'b1; @(negedge clk); start_set = 1'b0;
    chk("R6 start arms", start_bit, 1);
    repeat (3) @(negedge clk);
    chk("R6 armed without converting", conv_req, 0);
    exp_q.push_back(0);
    pulse_trig_measure(cnt);
    chk("R4 cold trigger fast latency", cnt, N_FAST + 3);
    repeat (2) @(negedge clk);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_cmpl("R6 completion");
    repeat (4) @(negedge clk);
    chk("R6 start kept after one-shot", start_bit, 1);
    chk("R7 busy trigger ignored", conv_req, 0);
    exp_q.push_back(0);
    pulse_trig_measure(cnt);
    chk("R6 warm trigger latency", cnt, 3);
    wait_cmpl("R6 completion");
    @(negedge clk);

    // no-wait scan (R9)
    style_sel = 2'b10;
    for (int s = 0; s < 4; s++) exp_q.push_back(s);
    pulse_trig_measure(cnt);
    for (int i = 0; i < 4; i++) begin
      wait_cmpl("R9 completion");
      @(negedge clk);
      if (i < 3) chk("R9 next slot immediate", conv_req, 1);
    end
    @(negedge clk);
    chk("R9 no-wait scan keeps start", start_bit, 1);
    chk("R9 scan stops after slot 3", conv_req, 0);
    chk("R9 slot wraps", slot, 0);
    pulse_clr();

    // hardware wait mode (R5)
    mode_sel = 2'b10; style_sel = 2'b00;
    start_set = 1'b1; @(negedge clk); start_set = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 sw start ignored", start_bit, 0);
    chk("R5 sw start no request", conv_req, 0);
    exp_q.push_back(0);
    pulse_trig_measure(cnt);
    chk("R5 wait-mode stabilize fast", cnt, N_FAST + 3);
    chk("R5 trigger sets start", start_bit, 1);
    wait_cmpl("R5 completion");
    @(negedge clk);
    chk("R5 one-shot clears start", start_bit, 0);
    chan_fast = 1'b0;
    exp_q.push_back(0);
    pulse_trig_measure(cnt);
    chk("R5 stabilize on every trigger slow", cnt, N_SLOW + 3);
    wait_cmpl("R5 completion");
    @(negedge clk);

    // wait-mode scan (R9)
    chan_fast = 1'b1; style_sel = 2'b10;
    for (int s = 0; s < 4; s++) exp_q.push_back(s);
    pulse_trig_measure(cnt);
    for (int i = 0; i < 4; i++) begin
      wait_cmpl("R9 completion");
      @(negedge clk);
      if (i < 3) chk("R9 wait scan no restabilize", conv_req, 1);
    end
    chk("R9 wait scan clears start", start_bit, 0);
    repeat (3) @(negedge clk);
    chk("R9 wait scan idle", conv_req, 0);

    // wait-mode sequential (R8)
    style_sel = 2'b01;
    repeat (2) exp_q.push_back(0);
    pulse_trig_measure(cnt);
    wait_cmpl("R8 completion");
    @(negedge clk);
    chk("R8 wait sequential no restabilize", conv_req, 1);
    wait_cmpl("R8 completion");
    pulse_clr();
    repeat (12) @(negedge clk);
    chk("R10 sequential stopped", conv_req, 0);
    chk("R11 all expected strobes seen", exp_q.size(), 0);
    finish_run();
  end

endmodule